// File: doc/BRIEF.md
# Dual-Rail Word Completion Detector

This block watches a word carried in dual-rail form, where each bit travels on a true rail and a false rail, and reports through one `done` signal whether the word has finished arriving or has finished clearing. A bit counts as carrying a value when either of its rails is high. The per-bit results are merged by a many-input Muller C-element, modelled here as a clocked state register. `done` rises once every bit carries a value. It falls once every bit has returned to the spacer state. Any other mixture leaves it where it was.

A pipeline stage controller uses `done` to decide two things: when the previous stage may clear its data, and when it may present the next word. Two single-cycle strobes mark each rising and each falling change of `done`. An error output flags any bit whose rails are both high.

Top module: `drcd_detector`

## Requirements
- R1: Bit i carries a value when `rail_t[i]` or `rail_f[i]` is high. The code {rail_t, rail_f} = 00 is the spacer, 01 is logic 0, 10 is logic 1, and 11 is illegal.
- R2: On a clock edge with `rst` high, `done`, `done_rise` and `done_fall` become 0.
- R3: If every bit carries a value at a clock edge, `done` is 1 after that edge.
- R4: If every bit is spacer at a clock edge, `done` is 0 after that edge.
- R5: If some bits carry a value and others are spacer at a clock edge, `done` keeps its previous value after that edge.
- R6: `done_rise` is 1 for exactly the one cycle after the edge at which `done` changed from 0 to 1, and is 0 otherwise.
- R7: `done_fall` is 1 for exactly the one cycle after the edge at which `done` changed from 1 to 0, and is 0 otherwise.
- R8: `code_err` is combinational. It is 1 in the same cycle whenever any bit has code 11, and 0 otherwise.
- R9: A bit with the illegal code 11 counts as carrying a value when the bits are merged.
- R10: A reset applied while `done` is 1 and the word is full clears `done` even though the inputs still meet the set condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the merge state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rail_t | input | WIDTH | True rail of each bit |
| rail_f | input | WIDTH | False rail of each bit |
| done | output | 1 | C-element state: 1 = word complete, 0 = word empty |
| done_rise | output | 1 | One-cycle strobe after `done` goes 0 to 1 |
| done_fall | output | 1 | One-cycle strobe after `done` goes 1 to 0 |
| code_err | output | 1 | Some bit carries the illegal code 11 |

## Verification
The bench fills and drains the word one bit at a time in shuffled order. It checks every intermediate state: a detector that used a plain AND would drop `done` on the first bit to clear, and one that used an OR would raise it on the first bit to arrive. Partial fills that turn back before completing check that `done` never moves on a half-full word, and a design that registered the wrong direction would produce spurious strobes. Illegal codes are injected into otherwise full words to catch a per-bit merge that ignores one rail or fails to flag the clash. A reset with a full word checks that reset wins over the set condition.

// File: rtl/drcd_pkg.sv
package drcd_pkg;

    typedef enum logic [1:0] {
        RC_SPACER  = 2'b00,
        RC_ZERO    = 2'b01,
        RC_ONE     = 2'b10,
        RC_ILLEGAL = 2'b11
    } rail_code_e;

    typedef struct packed {
        logic has_value;
        logic illegal;
    } bit_status_t;

    typedef enum logic [1:0] {
        MERGE_HOLD  = 2'b00,
        MERGE_SET   = 2'b01,
        MERGE_CLEAR = 2'b10
    } merge_cmd_e;

    function automatic rail_code_e pack_code(input logic r_true, input logic r_false);
        return rail_code_e'({r_true, r_false});
    endfunction

    function automatic bit_status_t classify(input rail_code_e code);
        bit_status_t s;
        s.has_value = (code != RC_SPACER);
        s.illegal   = (code == RC_ILLEGAL);
        return s;
    endfunction

endpackage

// File: rtl/drcd_bit_scan.sv
module drcd_bit_scan
    import drcd_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] rail_t,
    input  logic [WIDTH-1:0] rail_f,
    output logic [WIDTH-1:0] has_value,
    output logic [WIDTH-1:0] illegal
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        rail_code_e  code;
        bit_status_t stat;
        always_comb begin
            code         = pack_code(rail_t[i], rail_f[i]);
            stat         = classify(code);
            has_value[i] = stat.has_value;
            illegal[i]   = stat.illegal;
        end
    end
endmodule

// File: rtl/drcd_merge.sv
module drcd_merge
    import drcd_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] has_value,
    output merge_cmd_e       cmd
);
    logic all_set;
    logic any_set;

    always_comb begin
        all_set = &has_value;
        any_set = |has_value;
        if (all_set)
            cmd = MERGE_SET;
        else if (!any_set)
            cmd = MERGE_CLEAR;
        else
            cmd = MERGE_HOLD;
    end
endmodule

// File: rtl/drcd_state.sv
module drcd_state
    import drcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  merge_cmd_e cmd,
    output logic       state_q,
    output logic       rise_q,
    output logic       fall_q
);
    logic state_d;

    always_comb begin
        case (cmd)
            MERGE_SET:   state_d = 1'b1;
            MERGE_CLEAR: state_d = 1'b0;
            default:     state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= 1'b0;
            rise_q  <= 1'b0;
            fall_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            rise_q  <= state_d & ~state_q;
            fall_q  <= ~state_d & state_q;
        end
    end
endmodule

// File: rtl/drcd_detector.sv
module drcd_detector
    import drcd_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] rail_t,
    input  logic [WIDTH-1:0] rail_f,
    output logic             done,
    output logic             done_rise,
    output logic             done_fall,
    output logic             code_err
);
    logic [WIDTH-1:0] has_value;
    logic [WIDTH-1:0] illegal;
    merge_cmd_e       cmd;

    drcd_bit_scan #(.WIDTH(WIDTH)) scan_i (
        .rail_t    (rail_t),
        .rail_f    (rail_f),
        .has_value (has_value),
        .illegal   (illegal)
    );

    drcd_merge #(.WIDTH(WIDTH)) merge_i (
        .has_value (has_value),
        .cmd       (cmd)
    );

    drcd_state state_i (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .state_q (done),
        .rise_q  (done_rise),
        .fall_q  (done_fall)
    );

    assign code_err = |illegal;
endmodule

// File: rtl/drcd_detector_chk.sv
module drcd_detector_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] rail_t,
    input logic [WIDTH-1:0] rail_f,
    input logic             done,
    input logic             done_rise,
    input logic             done_fall,
    input logic             code_err
);
    logic word_full;
    logic word_empty;
    assign word_full  = &(rail_t | rail_f);
    assign word_empty = ((rail_t | rail_f) == '0);

    a_r2_reset_clears: assert property (@(posedge clk)
        rst |=> (!done && !done_rise && !done_fall));

    a_r3_full_sets: assert property (@(posedge clk) disable iff (rst)
        word_full |=> done);

    a_r4_empty_clears: assert property (@(posedge clk) disable iff (rst)
        word_empty |=> !done);

    a_r5_mixed_holds: assert property (@(posedge clk) disable iff (rst)
        (!word_full && !word_empty) |=> $stable(done));

    a_r6_rise_strobe: assert property (@(posedge clk) disable iff (rst)
        done_rise |-> (done && !$past(done)));

    a_r7_fall_strobe: assert property (@(posedge clk) disable iff (rst)
        done_fall |-> (!done && $past(done)));

    a_r6_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done_rise, done_fall}));

    a_r8_no_err_no_clash: assert property (@(posedge clk) disable iff (rst)
        !code_err |-> ((rail_t & rail_f) == '0));
endmodule

bind drcd_detector drcd_detector_chk #(.WIDTH(WIDTH)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .rail_t    (rail_t),
    .rail_f    (rail_f),
    .done      (done),
    .done_rise (done_rise),
    .done_fall (done_fall),
    .code_err  (code_err)
);

// File: tb/drcd_detector_tb_top.sv
module drcd_detector_tb_top;
    localparam int W       = 8;
    localparam int CLK_PER = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] rail_t;
    logic [W-1:0] rail_f;
    logic         done, done_rise, done_fall, code_err;

    int n_cmp  = 0;
    int n_fail = 0;

    int m_state = 0;
    int m_rise  = 0;
    int m_fall  = 0;

    always #(CLK_PER/2) clk = ~clk;

    drcd_detector #(.WIDTH(W)) dut_i (
        .clk(clk), .rst(rst), .rail_t(rail_t), .rail_f(rail_f),
        .done(done), .done_rise(done_rise), .done_fall(done_fall),
        .code_err(code_err)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int count_valued();
        int n = 0;
        for (int i = 0; i < W; i++) if (rail_t[i] || rail_f[i]) n++;
        return n;
    endfunction

    function automatic int count_illegal();
        int n = 0;
        for (int i = 0; i < W; i++) if (rail_t[i] && rail_f[i]) n++;
        return n;
    endfunction

    // drive inputs at negedge, check code_err, advance model, compare after next edge
    task automatic step(input logic [W-1:0] t, input logic [W-1:0] f, input logic r);
        int    nv, ni, nxt;
        string req;
        rail_t = t; rail_f = f; rst = r;
        #1;
        ni = count_illegal();
        check("R8", "code_err", code_err, (ni > 0) ? 1 : 0);
        nv = count_valued();
        if (r) begin
            nxt = 0; req = (m_state == 1) ? "R10" : "R2";
        end else if (nv == W) begin
            nxt = 1; req = (ni > 0) ? "R9" : "R3";
        end else if (nv == 0) begin
            nxt = 0; req = "R4";
        end else begin
            nxt = m_state; req = "R5";
        end
        m_rise  = (!r && nxt == 1 && m_state == 0) ? 1 : 0;
        m_fall  = (!r && nxt == 0 && m_state == 1) ? 1 : 0;
        m_state = nxt;
        @(posedge clk);
        @(negedge clk);
        check(req, "done", done, m_state);
        check(r ? req : "R6", "done_rise", done_rise, m_rise);
        check(r ? req : "R7", "done_fall", done_fall, m_fall);
    endtask

    task automatic shuffle(ref int ord[W]);
        for (int i = 0; i < W; i++) ord[i] = i;
        for (int i = W - 1; i > 0; i--) begin
            int j = $urandom_range(i, 0);
            int tmp = ord[i];
            ord[i] = ord[j];
            ord[j] = tmp;
        end
    endtask

    // fill from current inputs in random order; stop after 'upto' bits
    task automatic fill(input int upto, input logic allow_bad);
        int ord[W];
        logic [W-1:0] t, f;
        shuffle(ord);
        t = rail_t; f = rail_f;
        for (int k = 0; k < upto; k++) begin
            int b = ord[k];
            if (allow_bad && k == upto - 1) begin
                t[b] = 1'b1; f[b] = 1'b1;   // R9: illegal code completes word
            end else if ($urandom_range(1, 0) == 1) begin
                t[b] = 1'b1; f[b] = 1'b0;
            end else begin
                t[b] = 1'b0; f[b] = 1'b1;
            end
            step(t, f, 1'b0);
        end
    endtask

    task automatic drain(input int upto);
        int ord[W];
        logic [W-1:0] t, f;
        shuffle(ord);
        t = rail_t; f = rail_f;
        for (int k = 0; k < upto; k++) begin
            t[ord[k]] = 1'b0; f[ord[k]] = 1'b0;
            step(t, f, 1'b0);
        end
    endtask

    initial begin
        #(CLK_PER * 150000);
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; rail_t = '0; rail_f = '0;
        @(negedge clk);
        step('0, '0, 1'b1);                 // R2 reset state
        step('0, '0, 1'b1);
        step('0, '0, 1'b0);                 // R4 empty stays low
        for (int rep = 0; rep < 20; rep++) begin
            fill(W, 1'b0);                  // R1 R3 R5 R6
            step(rail_t, rail_f, 1'b0);     // hold full, no second strobe
            drain(W);                       // R4 R5 R7
            step('0, '0, 1'b0);
        end
        for (int rep = 0; rep < 10; rep++) begin
            fill($urandom_range(W - 1, 1), 1'b0);   // R5 partial fill, done stays 0
            drain(count_valued());
            fill(W, 1'b0);
            drain($urandom_range(W - 1, 1));        // R5 partial drain, done stays 1
            fill(W - count_valued(), 1'b0);
            drain(W);
        end
        step(8'h00, 8'hFF, 1'b0);           // R1 all logic 0 is full
        step(8'h00, 8'h00, 1'b0);
        step(8'hFF, 8'h00, 1'b0);           // R1 all logic 1 is full
        step(8'h00, 8'h00, 1'b0);
        for (int rep = 0; rep < 5; rep++) begin
            fill(W, 1'b1);                  // R8 R9 illegal bit completes word
            drain(W);
        end
        step(8'h01, 8'h01, 1'b0);           // R8 lone illegal bit, R5 hold
        step(8'h00, 8'h00, 1'b0);
        fill(W, 1'b0);
        step(rail_t, rail_f, 1'b1);         // R10 reset beats full word
        step(rail_t, rail_f, 1'b0);         // full again: rises
        drain(W);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end
endmodule